// File: doc/BRIEF.md
# Serial Debug Port Register Reader

This block is the target end of a two-wire synchronous debug link. A host supplies a debug clock and shares one data line with the target. The data line is modelled here as separate input, output and output-enable pins. Every transaction begins with a header byte: seven address bits, most significant first, then a direction bit. Each byte on the link, header or data, is followed by a ninth clock period that carries a separator bit driven by the host. A separator of 1 ends the transaction. A separator of 0 lets it go on.

In a read, the target shifts register bytes out most significant bit first. If the host keeps sending 0 separators, the target streams consecutive registers. Its address pointer steps up by one after each byte but never passes the top of the read-only area (0x20); from there it repeats the same register. A write header loads the pointer, and the data bytes that follow are clocked through and discarded. All sampling happens in the system clock domain: the debug clock and data are synchronised, and the target acts on each detected rising edge of the debug clock. The register contents come from a 128-entry byte store that the surrounding logic preloads.

The block also decides when an external bus request may be acknowledged. A grant is possible only when the grant enable is set and no debug transaction is in progress. In other words, a grant can come only after a high separator has closed the operation.

Top module: `dbg_serial_target`

## Requirements
- R1: After reset, `dbg_oe`, `dbg_dout` and `bus_ack` are 0 and the target waits for a header.
- R2: The target samples `dbg_din` on each rising debug-clock edge. A header consists of 7 address bits sent most significant bit first, then a direction bit (1 = read, 0 = write), then a separator period.
- R3: In a read, data periods 1 to 8 present the register byte from D7 down to D0 on `dbg_dout` with `dbg_oe` = 1. Each bit is valid from the rising edge that closes the previous period. `dbg_oe` is 0 during header and separator periods.
- R4: A separator of 1 after a data byte ends the transaction, releases the line, and makes the next bits a new header.
- R5: A separator of 0 after a read byte makes the next byte come from the address one higher.
- R6: The read pointer stops at 0x20. A block read reaching 0x20 keeps returning register 0x20, and a block read started above 0x20 keeps returning the starting register.
- R7: In a write, `dbg_oe` stays 0 for the whole transaction, data bytes are consumed with their separators, and register contents are left unchanged.
- R8: `bus_ack` is 1 only when the grant enable is set, `bus_req` is 1 and no transaction is in progress. The enable resets to 0, so no grant is given until it is set. After a high separator closes a transaction, a pending request is granted.
- R9: Dropping `bus_req` or clearing the grant enable removes `bus_ack` within two system clock cycles.
- R10: A preload write (`pre_we`) stores `pre_data` at `pre_addr`, and a later read of that address returns the stored value.
- R11: A separator of 1 directly after a header ends the transaction without any data period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_clk | input | 1 | Debug clock from the host |
| dbg_din | input | 1 | Data line as seen by the target |
| dbg_dout | output | 1 | Data bit driven by the target |
| dbg_oe | output | 1 | Target drives the data line when 1 |
| bus_req | input | 1 | External bus request |
| bus_ack | output | 1 | Bus request acknowledge |
| ack_cfg_we | input | 1 | Load strobe for the grant enable |
| ack_cfg_val | input | 1 | New grant enable value |
| pre_we | input | 1 | Register store preload strobe |
| pre_addr | input | DATA_W-1 | Preload address |
| pre_data | input | DATA_W | Preload data |

## Verification
The store is preloaded with an arithmetic pattern, and every one of the 128 addresses is read as a single byte. This separates shift order and addressing faults from storage faults. Block reads start below the 0x20 limit, cross it, and begin above it, which tells an incrementing pointer apart from a wrapping one or one that saturates at the wrong point. An aborted header and a full write transaction, each followed by a read, show whether separators and direction are decoded properly. The grant is watched on every debug bit of a transaction, and again as enable and request toggle, to separate gating by transaction state from plain request following.

// File: rtl/dbg_port_pkg.sv
`timescale 1ns/1ps
package dbg_port_pkg;
  typedef enum logic [2:0] {
    S_HDR,
    S_HSEP,
    S_RDATA,
    S_RSEP,
    S_WDATA,
    S_WSEP
  } dbg_state_e;
endpackage

// File: rtl/dbg_sync.sv
`timescale 1ns/1ps
module dbg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dbg_regfile.sv
`timescale 1ns/1ps
module dbg_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/dbg_busack_gate.sv
`timescale 1ns/1ps
module dbg_busack_gate (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_val,
  input  logic idle,
  input  logic bus_req,
  output logic bus_ack
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_val;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_ack <= 1'b0;
    else     bus_ack <= en_q & bus_req & idle;
  end

  p_no_ack_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !bus_ack);

  p_ack_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack);
endmodule

// File: rtl/dbg_serial_target.sv
`timescale 1ns/1ps
module dbg_serial_target
  import dbg_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RO_TOP      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_clk,
  input  logic              dbg_din,
  output logic              dbg_dout,
  output logic              dbg_oe,
  input  logic              bus_req,
  output logic              bus_ack,
  input  logic              ack_cfg_we,
  input  logic              ack_cfg_val,
  input  logic              pre_we,
  input  logic [DATA_W-2:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data
);
  localparam int AW      = DATA_W - 1;
  localparam int DW      = DATA_W;
  localparam int CNT_W   = $clog2(DW);
  localparam int CNT_MAX = DW - 1;

  // debug clock and data brought into the system domain
  logic [1:0] sync_q;
  logic       clk_prev;
  logic       rise;
  logic       bit_in;

  dbg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dbg_clk, dbg_din}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= sync_q[1];
  end

  assign rise   = sync_q[1] & ~clk_prev;
  assign bit_in = sync_q[0];

  // transaction state
  dbg_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [AW-1:0]     hdr_sh;
  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     addr_nx;
  logic              rd_dir_q;
  logic [DW-1:0]     out_sh;
  logic [DW-1:0]     rd_q;
  logic              idle;
  logic              hdr_done;
  logic              last_bit;

  dbg_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .wr_en   (pre_we),
    .wr_addr (pre_addr),
    .wr_data (pre_data),
    .rd_addr (addr_q),
    .rd_data (rd_q)
  );

  always_comb begin
    if (addr_q < AW'(RO_TOP)) addr_nx = addr_q + AW'(1);
    else                      addr_nx = addr_q;
  end

  assign last_bit = (cnt_q == CNT_W'(CNT_MAX));
  assign idle     = (state_q == S_HDR) && (cnt_q == '0);
  assign hdr_done = (state_q == S_HDR) && rise && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_HDR;
      cnt_q    <= '0;
      hdr_sh   <= '0;
      addr_q   <= '0;
      rd_dir_q <= 1'b0;
      out_sh   <= '0;
      dbg_dout <= 1'b0;
      dbg_oe   <= 1'b0;
    end else if (rise) begin
      unique case (state_q)
        S_HDR: begin
          if (last_bit) begin
            addr_q   <= hdr_sh;
            rd_dir_q <= bit_in;
            cnt_q    <= '0;
            state_q  <= S_HSEP;
          end else begin
            hdr_sh <= {hdr_sh[AW-2:0], bit_in};
            cnt_q  <= cnt_q + CNT_W'(1);
          end
        end
        S_HSEP, S_RSEP: begin
          cnt_q <= '0;
          if (bit_in) begin
            state_q <= S_HDR;
          end else if (state_q == S_RSEP || rd_dir_q) begin
            out_sh   <= rd_q;
            dbg_dout <= rd_q[DW-1];
            dbg_oe   <= 1'b1;
            state_q  <= S_RDATA;
          end else begin
            state_q <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (last_bit) begin
            cnt_q    <= '0;
            dbg_oe   <= 1'b0;
            dbg_dout <= 1'b0;
            addr_q   <= addr_nx;
            state_q  <= S_RSEP;
          end else begin
            cnt_q    <= cnt_q + CNT_W'(1);
            out_sh   <= {out_sh[DW-2:0], 1'b0};
            dbg_dout <= out_sh[DW-2];
          end
        end
        S_WDATA: begin
          if (last_bit) begin
            cnt_q   <= '0;
            state_q <= S_WSEP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_WSEP: begin
          cnt_q   <= '0;
          state_q <= bit_in ? S_HDR : S_WDATA;
        end
        default: state_q <= S_HDR;
      endcase
    end
  end

  dbg_busack_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (ack_cfg_we),
    .cfg_val (ack_cfg_val),
    .idle    (idle),
    .bus_req (bus_req),
    .bus_ack (bus_ack)
  );

  p_oe_in_data_r3: assert property (@(posedge clk) disable iff (rst)
    dbg_oe |-> (state_q == S_RDATA));

  p_hdr_released_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HDR) |-> !dbg_oe);

  p_write_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WDATA || state_q == S_WSEP) |-> !dbg_oe);

  p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
    !hdr_done |=> (addr_q == $past(addr_q) || addr_q == $past(addr_q) + AW'(1)));

  p_sat_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_q >= AW'(RO_TOP) && !hdr_done) |=> $stable(addr_q));

  p_busy_no_grant_r8: assert property (@(posedge clk) disable iff (rst)
    !idle |=> !$rose(bus_ack));
endmodule

// File: tb/test_dbg_serial_target.sv
`timescale 1ns/1ps
module test_dbg_serial_target;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbg_clk = 1'b0;
  logic       dbg_din = 1'b0;
  logic       dbg_dout, dbg_oe;
  logic       bus_req = 1'b0;
  logic       bus_ack;
  logic       ack_cfg_we = 1'b0;
  logic       ack_cfg_val = 1'b0;
  logic       pre_we = 1'b0;
  logic [6:0] pre_addr = '0;
  logic [7:0] pre_data = '0;

  int total = 0;
  int bad = 0;
  logic s_dout, s_oe;

  always #2.5 clk = ~clk;

  dbg_serial_target i_dbg_serial_target (
    .clk(clk), .rst(rst), .dbg_clk(dbg_clk), .dbg_din(dbg_din),
    .dbg_dout(dbg_dout), .dbg_oe(dbg_oe), .bus_req(bus_req), .bus_ack(bus_ack),
    .ack_cfg_we(ack_cfg_we), .ack_cfg_val(ack_cfg_val),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  function automatic int expv(int a);
    return (a * 37 + 11) & 255;
  endfunction

  function automatic int nexta(int a);
    return (a < 32) ? a + 1 : a;
  endfunction

  task automatic check(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one debug clock period: low half, sample just before the rising edge
  task automatic dbg_bit(input logic b);
    @(negedge clk);
    dbg_din = b;
    dbg_clk = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    s_dout  = dbg_dout;
    s_oe    = dbg_oe;
    dbg_clk = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic send_header(input int a, input logic rd, input logic sep, output int oe_seen);
    oe_seen = 0;
    for (int i = 6; i >= 0; i--) begin
      dbg_bit(a[i]);
      oe_seen |= int'(s_oe);
    end
    dbg_bit(rd);
    oe_seen |= int'(s_oe);
    dbg_bit(sep);
    oe_seen |= int'(s_oe);
  endtask

  task automatic read_bytes(input int a0, input int n, input string rq);
    int a, oe_h, val, oe_all;
    a = a0;
    send_header(a, 1'b1, 1'b0, oe_h);
    check("R3 header released", oe_h, 0);
    for (int k = 0; k < n; k++) begin
      val = 0;
      oe_all = 1;
      for (int b = 0; b < 8; b++) begin
        dbg_bit(1'b0);
        val = (val << 1) | int'(s_dout);
        oe_all &= int'(s_oe);
      end
      check(rq, val, expv(a));
      check("R3 driven in data", oe_all, 1);
      dbg_bit((k == n - 1) ? 1'b1 : 1'b0);
      check("R3 separator released", int'(s_oe), 0);
      a = nexta(a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int oe_seen, ackv;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe", int'(dbg_oe), 0);
    check("R1 dout", int'(dbg_dout), 0);
    check("R1 ack", int'(bus_ack), 0);

    // preload arithmetic pattern
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 7'(i); pre_data = 8'(expv(i));
    end
    @(negedge clk);
    pre_we = 1'b0;

    // R2 R3 R4: single-byte read of every address
    for (int i = 0; i < 128; i++) read_bytes(i, 1, "R2 single read");
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 released after end", int'(dbg_oe), 0);

    // R5 block reads, R6 saturation
    read_bytes(5, 3, "R5 block read");
    read_bytes(28, 8, "R6 crossing limit");
    read_bytes(48, 3, "R6 above limit");

    // R11 header followed by high separator
    send_header(7'h0C, 1'b1, 1'b1, oe_seen);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R11 no data after abort", oe_seen | int'(dbg_oe), 0);
    read_bytes(9, 1, "R11 next header accepted");

    // R7 write transaction
    send_header(7'h11, 1'b0, 1'b0, oe_seen);
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 8; b++) begin
        dbg_bit(b[0]);
        oe_seen |= int'(s_oe);
      end
      dbg_bit(k == 1);
      oe_seen |= int'(s_oe);
    end
    check("R7 line never driven", oe_seen, 0);
    read_bytes(17, 1, "R7 contents unchanged");

    // R10 preload overwrite
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 7'h40; pre_data = 8'h5A;
    @(negedge clk);
    pre_we = 1'b0;
    send_header(7'h40, 1'b1, 1'b0, oe_seen);
    ackv = 0;
    for (int b = 0; b < 8; b++) begin
      dbg_bit(1'b0);
      ackv = (ackv << 1) | int'(s_dout);
    end
    dbg_bit(1'b1);
    check("R10 preloaded value", ackv, 8'h5A);

    // R8 R9 bus grant
    @(negedge clk);
    bus_req = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 enable off after reset", int'(bus_ack), 0);
    ack_cfg_we = 1'b1; ack_cfg_val = 1'b1;
    @(negedge clk);
    ack_cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 grant when idle", int'(bus_ack), 1);
    ackv = 0;
    for (int i = 6; i >= 0; i--) begin
      dbg_bit(i[0]);
      ackv |= int'(bus_ack);
    end
    dbg_bit(1'b1);
    ackv |= int'(bus_ack);
    dbg_bit(1'b0);
    ackv |= int'(bus_ack);
    for (int b = 0; b < 8; b++) begin
      dbg_bit(1'b0);
      ackv |= int'(bus_ack);
    end
    check("R8 no grant during transaction", ackv, 0);
    dbg_bit(1'b1);
    repeat (2) @(negedge clk);
    check("R8 grant after high separator", int'(bus_ack), 1);
    bus_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 request dropped", int'(bus_ack), 0);
    bus_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 request back", int'(bus_ack), 1);
    ack_cfg_we = 1'b1; ack_cfg_val = 1'b0;
    @(negedge clk);
    ack_cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 enable cleared", int'(bus_ack), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule